// File: doc/BRIEF.md
# DSP Helper Operation Unit

This block is one execution slice of a 32- or 64-bit integer core. It takes two source operands, a third operand that carries either the old destination value or a selection mask, a 3-bit opcode and a byte-position field. It computes one scalar DSP helper result: a rounded average, a bitwise select, a 32-bit multiply-add or multiply-subtract into the destination, a byte swap or halfword swap, or a byte insert.

The result is held in a register and comes out one clock after the operands are accepted, together with a valid flag. The datapath width is set by the parameter `XLEN` (32 or 64). The byte-position field is `$clog2(XLEN/8)` bits wide.

There is no state machine. The only state is a single output stage with two conditions. In the idle/hold condition, `out_valid` is low and the result register keeps its value. In the loaded condition, `out_valid` is high and the result register holds the value computed from the operands sampled on the previous edge. The unit enters the loaded condition on any clock with `in_valid` high. It returns to the idle/hold condition on any clock with `in_valid` low, or on reset.

Top module: `dsp_misc_alu`

## Requirements
- R1: Opcode 0 (average): the result is bits XLEN..1 of (sign-extended `src_a`) + (sign-extended `src_b`) + 1, with both operands extended by one bit. Half values therefore round upward, and the result never overflows.
- R2: Opcode 1 (pick): each result bit comes from `src_a` where the same bit of `src_c` is 1, and from `src_b` where it is 0.
- R3: Opcode 2 (multiply-add): the low word is `src_c[31:0]` + low 32 bits of (`src_a[31:0]` × `src_b[31:0]`), computed modulo 2^32.
- R4: Opcode 3 (multiply-subtract): the low word is `src_c[31:0]` − low 32 bits of (`src_a[31:0]` × `src_b[31:0]`), computed modulo 2^32.
- R5: For opcodes 2 and 3, the 32-bit word is sign-extended to 64 bits when XLEN is 64, and is the whole result when XLEN is 32.
- R6: Opcode 4: inside every 16-bit halfword of `src_a`, the two bytes are exchanged. This covers two halfwords at XLEN 32 and four at XLEN 64.
- R7: Opcode 5: inside every 32-bit word of `src_a`, the two halfwords are exchanged.
- R8: Opcode 6 (insert): the result is `src_c` with byte number `byte_pos` replaced by `src_a[7:0]`. All other bytes of `src_c` are kept. `byte_pos` is 2 bits at XLEN 32 and 3 bits at XLEN 64.
- R9: When `in_valid` is high at a rising edge, `out_valid` is high after that edge and `result` shows the value for the sampled inputs.
- R10: When `in_valid` is low at a rising edge, `out_valid` is low after that edge and `result` keeps its previous value.
- R11: Opcode 7 is undefined. It yields a zero result, and `out_valid` is still asserted.
- R12: A synchronous, active-high `rst` clears both `out_valid` and `result` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and opcode are valid this cycle |
| opcode | input | 3 | Operation select (encodings in R1 to R11) |
| byte_pos | input | $clog2(XLEN/8) | Target byte for insert |
| src_a | input | XLEN | First source operand |
| src_b | input | XLEN | Second source operand |
| src_c | input | XLEN | Old destination value or pick mask |
| result | output | XLEN | Registered result |
| out_valid | output | 1 | Result valid flag |

## Verification
The bench builds two copies side by side, one with XLEN 64 and one with XLEN 32, and drives both with the same operands. At XLEN 64, the bench reaches the sign extension of the multiply words, the four-halfword byte swap and the 3-bit insert position. At XLEN 32, it covers the unextended multiply word and the case where position 7 is cut down to byte 3. Together the two copies exercise average overflow at both widths and the hold behaviour when `in_valid` is low.

// File: rtl/dsp_misc_pkg.sv
package dsp_misc_pkg;
    typedef enum logic [2:0] {
        OP_AVG  = 3'd0,
        OP_PICK = 3'd1,
        OP_MACC = 3'd2,
        OP_MSUB = 3'd3,
        OP_SWPB = 3'd4,
        OP_SWPH = 3'd5,
        OP_INSB = 3'd6,
        OP_RSVD = 3'd7
    } dmop_e;
endpackage

// File: rtl/dsp_misc_arith.sv
module dsp_misc_arith #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic [XLEN-1:0] c,
    input  logic            subtract,
    output logic [XLEN-1:0] avg_res,
    output logic [XLEN-1:0] mac_res
);
    logic [XLEN:0] wide_sum;
    logic [31:0]   prod_lo;
    logic [31:0]   acc_word;

    // widened sum never overflows; drop bit 0 to halve with upward rounding
    always_comb begin
        wide_sum = {a[XLEN-1], a} + {b[XLEN-1], b} + {{XLEN{1'b0}}, 1'b1};
        avg_res  = wide_sum[XLEN:1];
    end

    always_comb begin
        prod_lo  = a[31:0] * b[31:0];
        acc_word = subtract ? (c[31:0] - prod_lo) : (c[31:0] + prod_lo);
    end

    generate
        if (XLEN > 32) begin : g_sext
            assign mac_res = {{(XLEN-32){acc_word[31]}}, acc_word};
        end else begin : g_plain
            assign mac_res = acc_word;
        end
    endgenerate
endmodule

// File: rtl/dsp_misc_perm.sv
module dsp_misc_perm #(
    parameter int XLEN = 64,
    localparam int NB  = XLEN / 8,
    localparam int NH  = XLEN / 16,
    localparam int NW  = XLEN / 32,
    localparam int PW  = $clog2(NB)
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic [XLEN-1:0] c,
    input  logic [PW-1:0]   pos,
    output logic [XLEN-1:0] pick_res,
    output logic [XLEN-1:0] swpb_res,
    output logic [XLEN-1:0] swph_res,
    output logic [XLEN-1:0] ins_res
);
    assign pick_res = (a & c) | (b & ~c);

    generate
        for (genvar h = 0; h < NH; h++) begin : g_half
            assign swpb_res[h*16 +: 16] = {a[h*16 +: 8], a[h*16+8 +: 8]};
        end
        for (genvar w = 0; w < NW; w++) begin : g_word
            assign swph_res[w*32 +: 32] = {a[w*32 +: 16], a[w*32+16 +: 16]};
        end
        for (genvar k = 0; k < NB; k++) begin : g_byte
            assign ins_res[k*8 +: 8] = (pos == PW'(k)) ? a[7:0] : c[k*8 +: 8];
        end
    endgenerate
endmodule

// File: rtl/dsp_misc_alu.sv
module dsp_misc_alu
    import dsp_misc_pkg::*;
#(
    parameter int XLEN = 64,
    localparam int PW  = $clog2(XLEN / 8)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [2:0]      opcode,
    input  logic [PW-1:0]   byte_pos,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    input  logic [XLEN-1:0] src_c,
    output logic [XLEN-1:0] result,
    output logic            out_valid
);
    dmop_e           op;
    logic [XLEN-1:0] avg_res, mac_res, pick_res, swpb_res, swph_res, ins_res;
    logic [XLEN-1:0] next_res;

    assign op = dmop_e'(opcode);

    dsp_misc_arith #(.XLEN(XLEN)) u_arith (
        .a        (src_a),
        .b        (src_b),
        .c        (src_c),
        .subtract (op == OP_MSUB),
        .avg_res  (avg_res),
        .mac_res  (mac_res)
    );

    dsp_misc_perm #(.XLEN(XLEN)) u_perm (
        .a        (src_a),
        .b        (src_b),
        .c        (src_c),
        .pos      (byte_pos),
        .pick_res (pick_res),
        .swpb_res (swpb_res),
        .swph_res (swph_res),
        .ins_res  (ins_res)
    );

    always_comb begin
        unique case (op)
            OP_AVG:          next_res = avg_res;
            OP_PICK:         next_res = pick_res;
            OP_MACC, OP_MSUB: next_res = mac_res;
            OP_SWPB:         next_res = swpb_res;
            OP_SWPH:         next_res = swph_res;
            OP_INSB:         next_res = ins_res;
            default:         next_res = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= next_res;
            end
        end
    end

    assert_reset_clear_R12: assert property (@(posedge clk)
        rst |=> (!out_valid && result == '0));

    assert_valid_follow_R9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_hold_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(result)));

    assert_rsvd_zero_R11: assert property (@(posedge clk) disable iff (rst)
        (in_valid && opcode == 3'd7) |=> (out_valid && result == '0));

    assert_ins_target_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && opcode == 3'd6) |=>
            (result[$past(byte_pos)*8 +: 8] == $past(src_a[7:0])));
endmodule

// File: tb/dsp_misc_alu_tb.sv
`timescale 1ns/1ps
module dsp_misc_alu_tb;
    localparam real TCK = 8.0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [2:0]  opcode = '0;
    logic [2:0]  bpos = '0;
    logic [63:0] a = '0, b = '0, c = '0;
    logic [63:0] r64;
    logic [31:0] r32;
    logic        v64, v32;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #(TCK/2) clk = ~clk;

    dsp_misc_alu #(.XLEN(64)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
        .byte_pos(bpos), .src_a(a), .src_b(b), .src_c(c),
        .result(r64), .out_valid(v64)
    );

    dsp_misc_alu #(.XLEN(32)) u_dut32 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
        .byte_pos(bpos[1:0]), .src_a(a[31:0]), .src_b(b[31:0]), .src_c(c[31:0]),
        .result(r32), .out_valid(v32)
    );

    // behavioural model written from the requirements
    function automatic logic [63:0] model(input int xl, input logic [2:0] op,
            input logic [2:0] p, input logic [63:0] x, input logic [63:0] y,
            input logic [63:0] z);
        logic [64:0] s65;
        logic [32:0] s33;
        logic [31:0] pl, w;
        logic [63:0] r;
        int          pp;
        r = '0;
        case (op)
            3'd0: begin
                if (xl == 64) begin
                    s65 = {x[63], x} + {y[63], y} + 65'd1;
                    r = s65[64:1];
                end else begin
                    s33 = {x[31], x[31:0]} + {y[31], y[31:0]} + 33'd1;
                    r = {32'b0, s33[32:1]};
                end
            end
            3'd1: r = (x & z) | (y & ~z);
            3'd2, 3'd3: begin
                pl = x[31:0] * y[31:0];
                w  = (op == 3'd3) ? z[31:0] - pl : z[31:0] + pl;
                r  = (xl == 64) ? {{32{w[31]}}, w} : {32'b0, w};
            end
            3'd4: for (int h = 0; h < 4; h++) r[h*16 +: 16] = {x[h*16 +: 8], x[h*16+8 +: 8]};
            3'd5: for (int q = 0; q < 2; q++) r[q*32 +: 32] = {x[q*32 +: 16], x[q*32+16 +: 16]};
            3'd6: begin
                pp = (xl == 64) ? int'(p) : int'(p[1:0]);
                r = z;
                r[pp*8 +: 8] = x[7:0];
            end
            default: r = '0;
        endcase
        if (xl == 32) r = {32'b0, r[31:0]};
        return r;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic [2:0] p,
            input logic [63:0] x, input logic [63:0] y, input logic [63:0] z);
        @(negedge clk);
        in_valid = 1'b1; opcode = op; bpos = p; a = x; b = y; c = z;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // {opcode, pos, a, b, c}
    localparam int NV = 14;
    localparam logic [197:0] VEC [NV] = '{
        {3'd0, 3'd0, 64'h0000_0000_0000_0003, 64'h0000_0000_0000_0004, 64'h0},
        {3'd0, 3'd0, 64'hFFFF_FFFF_FFFF_FFFD, 64'hFFFF_FFFF_FFFF_FFFC, 64'h0},
        {3'd0, 3'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0},
        {3'd0, 3'd0, 64'h8000_0000_8000_0000, 64'h8000_0000_8000_0001, 64'h0},
        {3'd1, 3'd0, 64'hAAAA_AAAA_1234_5678, 64'h5555_5555_9ABC_DEF0, 64'hFF00_F0F0_0F0F_00FF},
        {3'd2, 3'd0, 64'h1234_5678_8000_0000, 64'hFFFF_0000_0000_0001, 64'hDEAD_BEEF_0000_0000},
        {3'd2, 3'd0, 64'h0000_0000_0001_0001, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0010},
        {3'd3, 3'd0, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0001, 64'h0},
        {3'd3, 3'd0, 64'h0000_0000_0000_0003, 64'h0000_0000_0000_0005, 64'h0000_0000_7FFF_FFFF},
        {3'd4, 3'd0, 64'h0102_0304_0506_0708, 64'h0, 64'h0},
        {3'd5, 3'd0, 64'h0102_0304_0506_0708, 64'h0, 64'h0},
        {3'd6, 3'd7, 64'h0000_0000_0000_00AB, 64'h0, 64'h1111_2222_3333_4444},
        {3'd6, 3'd1, 64'hFFFF_FFFF_FFFF_FF5C, 64'h0, 64'h8877_6655_4433_2211},
        {3'd7, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 64'h2}
    };
    localparam string TAGS [NV] = '{"R1", "R1", "R1", "R1", "R2", "R3_R5", "R3",
        "R4_R5", "R4", "R6", "R7", "R8", "R8", "R11"};

    initial begin
        // R12: reset clears valid and result
        repeat (3) @(negedge clk);
        check("R12 valid64", {63'b0, v64}, 64'd0);
        check("R12 result64", r64, 64'd0);
        check("R12 result32", {32'b0, r32}, 64'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [197:0] v;
            v = VEC[i];
            issue(v[197:195], v[194:192], v[191:128], v[127:64], v[63:0]);
            check({TAGS[i], " x64"}, r64, model(64, v[197:195], v[194:192], v[191:128], v[127:64], v[63:0]));
            check({TAGS[i], " x32"}, {32'b0, r32}, model(32, v[197:195], v[194:192], v[191:128], v[127:64], v[63:0]));
            check("R9 valid", {62'b0, v64, v32}, 64'd3);
        end

        // directed corner values computed by hand
        issue(3'd0, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0);
        check("R1 -1 avg 0 x64", r64, 64'h0);
        issue(3'd2, 3'd0, 64'h8000_0000, 64'h1, 64'h0);
        check("R5 sext x64", r64, 64'hFFFF_FFFF_8000_0000);
        check("R5 plain x32", {32'b0, r32}, 64'h8000_0000);
        issue(3'd6, 3'd7, 64'hAB, 64'h0, 64'h0);
        check("R8 pos7 x64", r64, 64'hAB00_0000_0000_0000);
        check("R8 pos7 cut x32", {32'b0, r32}, 64'hAB00_0000);
        issue(3'd7, 3'd0, 64'h5, 64'h5, 64'h5);
        check("R11 valid", {63'b0, v64}, 64'd1);
        check("R11 zero", r64, 64'd0);

        // R10: inputs change with in_valid low; result held, valid low
        issue(3'd5, 3'd0, 64'h1111_2222_3333_4444, 64'h0, 64'h0);
        @(negedge clk);
        in_valid = 1'b0; opcode = 3'd4; a = 64'hDEAD_BEEF_CAFE_F00D;
        @(negedge clk);
        check("R10 valid low", {62'b0, v64, v32}, 64'd0);
        check("R10 held x64", r64, 64'h2222_1111_4444_3333);
        check("R10 held x32", {32'b0, r32}, 64'h4444_3333);

        // R12: reset after activity
        rst = 1'b1;
        @(negedge clk);
        check("R12 clear again", {r64[62:0], v64}, 64'd0);
        rst = 1'b0;

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(TCK * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule